// File: doc/BRIEF.md
# FIFO Threshold Monitor with Re-arm Hysteresis

This block compares the fill levels of two FIFOs, an import FIFO that fills from a link and a free-list FIFO that the receive path drains, against programmable 9-bit limits. For each FIFO it raises a registered almost-full flag and a registered almost-empty flag. It also emits a one-cycle increment strobe for an external diagnostic counter. The strobe fires when the import FIFO climbs past its almost-full limit, or when the free-list FIFO drops under its almost-empty limit.

The free-list trigger has hysteresis. Once it has produced a strobe, a small two-state machine (ARMED, HOLD) blocks further free-list strobes. The block stays in HOLD until the free-list level has climbed back to a separate resume limit. The resume limit acts only on this gating; the flags never see it.

All three limits come from a single write-only 32-bit word. Software cannot read the limits back. Their effect is seen through the flags and the strobe.

Top module: `fifo_thresh_mon`

States of the strobe machine:
- ARMED: a free-list almost-empty onset produces a strobe. Transition ARMED to HOLD on that onset.
- HOLD: free-list onsets produce no strobe. Transition HOLD to ARMED on the first clock edge at which free-list depth >= resume limit.

## Requirements
- R1: After reset all four flags and the strobe are 0, the machine is ARMED, and the limits are almost-empty = 0, almost-full = 511, resume = 0.
- R2: A clock edge with `thr_wr_en` high loads the almost-empty limit from `thr_wr_data[8:0]`, the almost-full limit from `thr_wr_data[17:9]` and the resume limit from `thr_wr_data[26:18]`. Bits 31:27 are ignored. Without `thr_wr_en` the limits keep their values whatever `thr_wr_data` holds. A new limit first applies to the comparison made at the following edge.
- R3: At each edge, `imp_afull` and `free_afull` take the value (depth > almost-full limit) of their FIFO's depth input.
- R4: At each edge, `imp_aempty` and `free_aempty` take the value (depth < almost-empty limit) of their FIFO's depth input.
- R5: The import FIFO causes a strobe only at the onset of its almost-full condition, meaning the condition is true at this edge and was false at the previous edge. While the condition persists there is no further import strobe.
- R6: In ARMED, the onset of the free-list almost-empty condition causes a strobe and moves the machine to HOLD.
- R7: In HOLD, free-list onsets cause no strobe. The machine returns to ARMED at an edge where free-list depth >= resume limit. The resume limit never changes any flag.
- R8: `cnt_inc` is registered at the same edge as the flags and stays high for one cycle per qualifying edge. If both sources qualify at the same edge, there is still one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr_en | input | 1 | Load strobe for the limit word |
| thr_wr_data | input | 32 | Packed limit word |
| imp_depth | input | DEPTH_W | Current import FIFO level |
| free_depth | input | DEPTH_W | Current free-list FIFO level |
| imp_afull | output | 1 | Import level above almost-full limit |
| imp_aempty | output | 1 | Import level below almost-empty limit |
| free_afull | output | 1 | Free-list level above almost-full limit |
| free_aempty | output | 1 | Free-list level below almost-empty limit |
| cnt_inc | output | 1 | One-cycle counter increment strobe |

## Verification
The bench targets these cases:
- The free-list level dips below the almost-empty limit a second time before it reaches the resume limit. A design without hysteresis would strobe twice. The case also checks that `free_aempty` still rises, so a design that wrongly gated the flag is caught as well.
- The import level stays above the almost-full limit for several cycles. A level-sensitive design would strobe every cycle.
- Levels equal to each limit are tested. This exposes a swapped `>`/`>=` comparison.
- Limit words are written with the top five bits set. This catches a field decode that is misaligned or one bit too wide.
- Random levels clustered around the limits, together with random rewrites of the limits, catch a mis-timed resume rearm and a single edge that should give one pulse but gives two.

// File: rtl/fthm_pkg.sv
package fthm_pkg;
    localparam int THR_W = 9;
    localparam int CFG_W = 32;

    typedef logic [THR_W-1:0] thr_t;

    // Field order matches the packed limit word (resume on top, aempty at bit 0)
    typedef struct packed {
        thr_t resume;
        thr_t afull;
        thr_t aempty;
    } thr_set_t;

    typedef enum logic [0:0] {
        EV_ARMED = 1'b0,
        EV_HOLD  = 1'b1
    } ev_state_e;
endpackage

// File: rtl/fthm_cfg.sv
module fthm_cfg
    import fthm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output thr_set_t         thr_o
);
    localparam int USED_W = 3 * THR_W;

    thr_set_t thr_q;
    logic     unused_hi_bits;

    assign unused_hi_bits = ^wr_data[CFG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q.resume <= '0;
            thr_q.afull  <= '1;
            thr_q.aempty <= '0;
        end else if (wr_en) begin
            thr_q <= thr_set_t'(wr_data[USED_W-1:0]);
        end
    end

    assign thr_o = thr_q;

    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(thr_q)); // R2
endmodule

// File: rtl/fthm_cmp.sv
module fthm_cmp
    import fthm_pkg::*;
#(
    parameter int DEPTH_W = 10,
    parameter int N_FIFO  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_FIFO-1:0][DEPTH_W-1:0] depth_i,
    input  thr_set_t                      thr_i,
    output logic [N_FIFO-1:0]             afull_now_o,
    output logic [N_FIFO-1:0]             aempty_now_o,
    output logic [N_FIFO-1:0]             afull_q_o,
    output logic [N_FIFO-1:0]             aempty_q_o
);
    logic [DEPTH_W-1:0] af_lim;
    logic [DEPTH_W-1:0] ae_lim;

    assign af_lim = DEPTH_W'(thr_i.afull);
    assign ae_lim = DEPTH_W'(thr_i.aempty);

    for (genvar g = 0; g < N_FIFO; g++) begin : g_fifo
        assign afull_now_o[g]  = depth_i[g] > af_lim;
        assign aempty_now_o[g] = depth_i[g] < ae_lim;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                afull_q_o[g]  <= 1'b0;
                aempty_q_o[g] <= 1'b0;
            end else begin
                afull_q_o[g]  <= afull_now_o[g];
                aempty_q_o[g] <= aempty_now_o[g];
            end
        end
    end
endmodule

// File: rtl/fthm_evt.sv
module fthm_evt
    import fthm_pkg::*;
#(
    parameter int DEPTH_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               af_now_i,
    input  logic               af_prev_i,
    input  logic               ae_now_i,
    input  logic               ae_prev_i,
    input  logic [DEPTH_W-1:0] free_depth_i,
    input  thr_t               resume_i,
    output logic               pulse_o,
    output ev_state_e          state_o
);
    ev_state_e state_q;
    ev_state_e state_d;
    logic      af_fire;
    logic      ae_fire;
    logic      resume_hit;

    assign resume_hit = free_depth_i >= DEPTH_W'(resume_i);

    always_comb begin
        af_fire = af_now_i && !af_prev_i;
        ae_fire = 1'b0;
        state_d = state_q;
        unique case (state_q)
            EV_ARMED: begin
                if (ae_now_i && !ae_prev_i) begin
                    ae_fire = 1'b1;
                    state_d = EV_HOLD;
                end
            end
            EV_HOLD: begin
                if (resume_hit) begin
                    state_d = EV_ARMED;
                end
            end
            default: state_d = EV_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EV_ARMED;
            pulse_o <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_o <= af_fire || ae_fire;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/fifo_thresh_mon.sv
module fifo_thresh_mon
    import fthm_pkg::*;
#(
    parameter int DEPTH_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               thr_wr_en,
    input  logic [31:0]        thr_wr_data,
    input  logic [DEPTH_W-1:0] imp_depth,
    input  logic [DEPTH_W-1:0] free_depth,
    output logic               imp_afull,
    output logic               imp_aempty,
    output logic               free_afull,
    output logic               free_aempty,
    output logic               cnt_inc
);
    localparam int N_FIFO = 2;
    localparam int IDX_IMP  = 0;
    localparam int IDX_FREE = 1;

    thr_set_t                       thr;
    logic [N_FIFO-1:0][DEPTH_W-1:0] depths;
    logic [N_FIFO-1:0]              af_now;
    logic [N_FIFO-1:0]              ae_now;
    logic [N_FIFO-1:0]              af_q;
    logic [N_FIFO-1:0]              ae_q;
    ev_state_e                      ev_state;

    assign depths[IDX_IMP]  = imp_depth;
    assign depths[IDX_FREE] = free_depth;

    fthm_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (thr_wr_en),
        .wr_data (thr_wr_data),
        .thr_o   (thr)
    );

    fthm_cmp #(.DEPTH_W(DEPTH_W), .N_FIFO(N_FIFO)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .depth_i      (depths),
        .thr_i        (thr),
        .afull_now_o  (af_now),
        .aempty_now_o (ae_now),
        .afull_q_o    (af_q),
        .aempty_q_o   (ae_q)
    );

    fthm_evt #(.DEPTH_W(DEPTH_W)) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .af_now_i     (af_now[IDX_IMP]),
        .af_prev_i    (af_q[IDX_IMP]),
        .ae_now_i     (ae_now[IDX_FREE]),
        .ae_prev_i    (ae_q[IDX_FREE]),
        .free_depth_i (free_depth),
        .resume_i     (thr.resume),
        .pulse_o      (cnt_inc),
        .state_o      (ev_state)
    );

    assign imp_afull   = af_q[IDX_IMP];
    assign imp_aempty  = ae_q[IDX_IMP];
    assign free_afull  = af_q[IDX_FREE];
    assign free_aempty = ae_q[IDX_FREE];

    AST_PULSE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc |-> (imp_afull || free_aempty)); // R8
    AST_AF_ONSET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && !free_aempty) |-> $rose(imp_afull)); // R5
    AST_AE_PULSE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && !imp_afull) |-> (ev_state == EV_HOLD && $rose(free_aempty))); // R6
    AST_HOLD_BLOCKS_AE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_state == EV_HOLD && !imp_afull && !$rose(imp_afull)) |=> (!cnt_inc || imp_afull)); // R7
endmodule

// File: tb/fifo_thresh_mon_tb.sv
module fifo_thresh_mon_tb_top;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          thr_wr_en = 1'b0;
    logic [31:0]   thr_wr_data = '0;
    logic [DW-1:0] imp_depth = '0;
    logic [DW-1:0] free_depth = '0;
    logic          imp_afull, imp_aempty, free_afull, free_aempty, cnt_inc;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    int m_ae, m_af, m_res;
    bit m_iaf_p, m_fae_p, m_armed;
    bit e_iaf, e_iae, e_faf, e_fae, e_inc;

    always #5 clk = ~clk;

    fifo_thresh_mon #(.DEPTH_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
        .imp_depth(imp_depth), .free_depth(free_depth),
        .imp_afull(imp_afull), .imp_aempty(imp_aempty),
        .free_afull(free_afull), .free_aempty(free_aempty), .cnt_inc(cnt_inc)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_ae = 0; m_af = 511; m_res = 0;
        m_iaf_p = 0; m_fae_p = 0; m_armed = 1;
        e_iaf = 0; e_iae = 0; e_faf = 0; e_fae = 0; e_inc = 0;
    endfunction

    function automatic void model_edge(input bit we, input logic [31:0] wd, input int id, input int fd);
        bit c_iaf, c_iae, c_faf, c_fae, af_ev, ae_ev;
        c_iaf = id > m_af;
        c_iae = id < m_ae;
        c_faf = fd > m_af;
        c_fae = fd < m_ae;
        af_ev = c_iaf && !m_iaf_p;
        ae_ev = m_armed && c_fae && !m_fae_p;
        if (m_armed) m_armed = !ae_ev;
        else         m_armed = (fd >= m_res);
        e_iaf = c_iaf; e_iae = c_iae; e_faf = c_faf; e_fae = c_fae;
        e_inc = af_ev || ae_ev;
        m_iaf_p = c_iaf; m_fae_p = c_fae;
        if (we) begin
            m_ae  = int'(wd[8:0]);
            m_af  = int'(wd[17:9]);
            m_res = int'(wd[26:18]);
        end
    endfunction

    task automatic step(input bit we, input logic [31:0] wd, input int id, input int fd,
                        input string tag_flag, input string tag_inc);
        @(negedge clk);
        thr_wr_en   = we;
        thr_wr_data = wd;
        imp_depth   = DW'(id);
        free_depth  = DW'(fd);
        model_edge(we, wd, id, fd);
        @(posedge clk);
        #1;
        chk(tag_flag, "imp_afull",   imp_afull,   e_iaf);
        chk(tag_flag, "free_afull",  free_afull,  e_faf);
        chk(tag_flag, "imp_aempty",  imp_aempty,  e_iae);
        chk(tag_flag, "free_aempty", free_aempty, e_fae);
        chk(tag_inc,  "cnt_inc",     cnt_inc,     e_inc);
    endtask

    function automatic int near(input int lim);
        int v;
        v = lim + int'($urandom_range(0, 6)) - 3;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] wd;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "imp_afull",   imp_afull,   1'b0);
        chk("R1", "free_aempty", free_aempty, 1'b0);
        chk("R1", "cnt_inc",     cnt_inc,     1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: default limits (afull 511, aempty 0)
        step(0, '0, 511, 0, "R1", "R1");
        step(0, '0, 512, 0, "R1", "R5");
        step(0, '0, 0, 0, "R1", "R5");

        // R2: load aempty=10 afull=20 resume=40, top bits set (ignored)
        wd = {5'h1F, 9'd40, 9'd20, 9'd10};
        step(1, wd, 5, 30, "R2", "R2");
        step(0, 32'hFFFF_FFFF, 5, 30, "R2", "R2");   // R2: data without enable ignored
        step(0, '0, 20, 10, "R3", "R5");             // boundaries: equal to limits
        step(0, '0, 5, 8, "R4", "R6");               // R6: first onset strobes
        step(0, '0, 5, 15, "R4", "R7");
        step(0, '0, 5, 5, "R7", "R7");               // R7: second onset blocked, flag still rises
        step(0, '0, 5, 39, "R7", "R7");
        step(0, '0, 5, 40, "R7", "R7");              // R7: resume reached
        step(0, '0, 5, 3, "R6", "R6");               // R6: strobes again
        step(0, '0, 25, 3, "R3", "R5");              // R5: af onset
        step(0, '0, 30, 3, "R3", "R5");              // R5: no repeat
        step(0, '0, 31, 3, "R3", "R5");
        step(0, '0, 5, 50, "R7", "R7");
        step(0, '0, 40, 2, "R8", "R8");              // R8: both at once, single pulse
        step(0, '0, 5, 50, "R8", "R8");

        // random phase around the limits
        for (int i = 0; i < 6000; i++) begin
            bit we;
            int id, fd;
            we = ($urandom_range(0, 49) == 0);
            wd = $urandom();
            if (we) wd[26:0] = {9'($urandom_range(0, 80)), 9'($urandom_range(0, 80)),
                                9'($urandom_range(0, 80))};
            case ($urandom_range(0, 3))
                0: id = near(m_af);
                1: id = near(m_ae);
                default: id = int'($urandom_range(0, 100));
            endcase
            case ($urandom_range(0, 3))
                0: fd = near(m_ae);
                1: fd = near(m_res);
                default: fd = int'($urandom_range(0, 100));
            endcase
            step(we, wd, id, fd, "R3/R4", "R5/R6/R7/R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule